// File: doc/BRIEF.md
# Replay FIFO with Saved Read Position

This block is a single-clock first-in first-out buffer for 9-bit words that can rewind its read side. A host writes words with an active-low write strobe and takes them out, oldest first, with an active-low read strobe. Writes are refused when the buffer holds its full depth, and reads are refused when it is empty.

A saved-position register lets a consumer replay a packet. Pulsing the active-low save input records the current read position. Pulsing the active-low rewind input moves the read side back to that recorded position, so every word from there on is read out again. The rewind can be repeated any number of times. On a rewind the word count is rebuilt from the write position and the saved position. The count leaves the block so that a separate status-flag generator can decode it.

The depth is a power of two set by `ADDR_W`. A deployment of 8192 words uses `ADDR_W = 13`; the default is smaller so the array stays modest. A producer must not write more than one full depth past the saved position. Doing so overwrites words that are still needed for a replay.

Top module: `fifo_mark_rt`

## Requirements
- R1: Accepted reads return words in the order they were accepted for writing. The word appears on `rd_data` one clock after the read strobe is sampled.
- R2: After reset the count is 0, `empty` is 1 and `full` is 0. The read, write and saved positions are all 0, so a rewind issued after reset makes the count equal to the number of words written since reset.
- R3: A write strobe sampled while the count equals the depth is ignored. The count does not change, and the refused word is never read out.
- R4: `rd_data` changes only on an accepted read. A read strobe sampled while the count is 0 is ignored, and both the count and `rd_data` hold their values.
- R5: When a read and a write are both accepted in the same cycle, the count is unchanged.
- R6: A sampled `mark_n` low, with `rt_n` high, saves the read position as it was before any read in that cycle. A later rewind resumes reading at the word found at that position.
- R7: A sampled `rt_n` low loads the read position from the saved position. It also sets the count to the write position (after any write in that cycle) minus the saved position. Positions carry one wrap bit, so the count ranges from 0 to the depth.
- R8: A rewind can be issued again after any number of reads and replays the same words each time.
- R9: When `mark_n` and `rt_n` are both low in one cycle, the rewind takes effect and the saved position keeps its old value.
- R10: `full` is 1 exactly when the count equals the depth, and `empty` is 1 exactly when the count is 0.
- R11: In a rewind cycle a read strobe is ignored and a write strobe is still accepted if the buffer is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_n | input | 1 | Active-low write strobe |
| wr_data | input | DATA_W (9) | Word to store |
| rd_n | input | 1 | Active-low read strobe |
| rd_data | output | DATA_W (9) | Last word read |
| mark_n | input | 1 | Active-low save of the read position |
| rt_n | input | 1 | Active-low rewind to the saved position |
| word_count | output | ADDR_W+1 | Words currently readable, 0 to depth |
| full | output | 1 | Count equals the depth |
| empty | output | 1 | Count is zero |

## Verification
The hardest case to reach is a rewind whose recomputed count must account for both pointer wrap and a write accepted in the same cycle. The rewind is also racing a save and a read. To get there, the stimulus first streams simultaneous reads and writes so that every position wraps past the depth. It then sweeps the save point across every offset of a partly drained buffer. At each offset it rewinds twice, adds a write in some of the rewind cycles, and asserts save and rewind together with a read. The expected count and data come from an arithmetic model of the positions.

// File: rtl/fifo_mark_rt_pkg.sv
package fifo_mark_rt_pkg;

  // per-cycle decision taken from the sampled strobes and the current count
  typedef struct packed {
    logic wr_ok;    // write accepted
    logic rd_ok;    // read accepted
    logic rewind;   // read position reloaded from saved position
    logic capture;  // read position saved
  } fifo_op_t;

endpackage

// File: rtl/fifo_strobe_qual.sv
module fifo_strobe_qual
  import fifo_mark_rt_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int CNT_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             mark_n,
  input  logic             rt_n,
  input  logic [CNT_W-1:0] cnt,
  output fifo_op_t         op,
  output logic             is_full,
  output logic             is_empty
);

  always_comb begin
    is_full    = (cnt == CNT_W'(DEPTH));
    is_empty   = (cnt == '0);
    op.rewind  = ~rt_n;
    op.capture = ~mark_n & rt_n;
    op.wr_ok   = ~wr_n & ~is_full;
    op.rd_ok   = ~rd_n & rt_n & ~is_empty;
  end

endmodule

// File: rtl/fifo_ptr_ctl.sv
module fifo_ptr_ctl
  import fifo_mark_rt_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int PTR_W = ADDR_W + 1,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifo_op_t          op,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic [CNT_W-1:0]  cnt
);

  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [PTR_W-1:0] mk_q, mk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] span;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    mk_d  = mk_q;
    cnt_d = cnt_q;
    if (op.wr_ok) wr_d = wr_q + PTR_W'(1);
    span = wr_d - mk_q;
    if (op.rewind) begin
      rd_d  = mk_q;
      cnt_d = CNT_W'(span);
    end else begin
      if (op.capture) mk_d = rd_q;
      if (op.rd_ok) rd_d = rd_q + PTR_W'(1);
      unique case ({op.wr_ok, op.rd_ok})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      mk_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      mk_q  <= mk_d;
      cnt_q <= cnt_d;
    end
  end

  assign waddr = wr_q[ADDR_W-1:0];
  assign raddr = rd_q[ADDR_W-1:0];
  assign cnt   = cnt_q;

endmodule

// File: rtl/fifo_word_store.sv
module fifo_word_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // array has no reset so it maps onto a plain memory macro
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/fifo_mark_rt.sv
module fifo_mark_rt
  import fifo_mark_rt_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_n,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mark_n,
  input  logic              rt_n,
  output logic [CNT_W-1:0]  word_count,
  output logic              full,
  output logic              empty
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  fifo_op_t          op;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fifo_strobe_qual #(.ADDR_W(ADDR_W)) u_qual (
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .mark_n   (mark_n),
    .rt_n     (rt_n),
    .cnt      (cnt),
    .op       (op),
    .is_full  (full),
    .is_empty (empty)
  );

  fifo_ptr_ctl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op    (op),
    .waddr (waddr),
    .raddr (raddr),
    .cnt   (cnt)
  );

  fifo_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (op.wr_ok),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (op.rd_ok),
    .raddr (raddr),
    .rdata (rd_data)
  );

  assign word_count = cnt;

endmodule

// File: rtl/fifo_mark_rt_chk.sv
module fifo_mark_rt_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9,
  localparam int CNT_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic              rt_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  word_count,
  input logic              full,
  input logic              empty
);

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_count <= CNT_W'(DEPTH)); // R10

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_n && rd_n && rt_n) |=> (word_count == CNT_W'(DEPTH))); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rd_n && wr_n && rt_n) |=> (word_count == '0)); // R4

  AST_BALANCED_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !empty && !wr_n && !rd_n && rt_n) |=> $stable(word_count)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || !rt_n || empty) |=> $stable(rd_data)); // R4

endmodule

bind fifo_mark_rt fifo_mark_rt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_n       (wr_n),
  .rd_n       (rd_n),
  .rt_n       (rt_n),
  .rd_data    (rd_data),
  .word_count (word_count),
  .full       (full),
  .empty      (empty)
);

// File: tb/fifo_mark_rt_test.sv
module fifo_mark_rt_test;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, wr_n, rd_n, mark_n, rt_n;
  logic [DW-1:0] wr_data, rd_data;
  logic [AW:0]   word_count;
  logic          full, empty;

  fifo_mark_rt #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_data(wr_data),
    .rd_n(rd_n), .rd_data(rd_data), .mark_n(mark_n), .rt_n(rt_n),
    .word_count(word_count), .full(full), .empty(empty)
  );

  int checks = 0;
  int errors = 0;
  int vseed  = 0;

  logic [DW-1:0] mm [D];
  int mwr, mrd, mmk, mcnt;
  logic [DW-1:0] mdout;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_n = 1'b1; rd_n = 1'b1; mark_n = 1'b1; rt_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    mwr = 0; mrd = 0; mmk = 0; mcnt = 0; mdout = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(word_count == 0, "R2", "count after reset", int'(word_count), 0);
    chk(empty == 1'b1, "R2", "empty after reset", int'(empty), 1);
    chk(full == 1'b0, "R2", "full after reset", int'(full), 0);
  endtask

  function automatic logic [DW-1:0] next_word();
    vseed++;
    return DW'((vseed * 37 + 11) % 509);
  endfunction

  task automatic step(input bit w, input bit r, input bit m, input bit t,
                      input string tag);
    bit aw, ar;
    int rd0;
    logic [DW-1:0] d;
    d = next_word();
    @(negedge clk);
    wr_n = !w; rd_n = !r; mark_n = !m; rt_n = !t; wr_data = d;
    @(posedge clk);
    aw  = w && (mcnt < D);
    ar  = r && !t && (mcnt > 0);
    rd0 = mrd;
    if (aw) begin
      mm[mwr % D] = d;
      mwr = (mwr + 1) % (2 * D);
    end
    if (t) begin
      mrd  = mmk;
      mcnt = (mwr - mmk + 2 * D) % (2 * D);
    end else begin
      if (m) mmk = rd0;
      if (ar) begin
        mdout = mm[mrd % D];
        mrd   = (mrd + 1) % (2 * D);
      end
      mcnt = mcnt + int'(aw) - int'(ar);
    end
    #2;
    chk(int'(word_count) == mcnt, tag, "word count", int'(word_count), mcnt);
    chk(full == (mcnt == D), "R10", "full flag", int'(full), int'(mcnt == D));
    chk(empty == (mcnt == 0), "R10", "empty flag", int'(empty), int'(mcnt == 0));
    chk(rd_data == mdout, ar ? "R1" : "R4", "read data", int'(rd_data), int'(mdout));
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    wr_data = '0;
    rst_n   = 1'b0;
    do_reset();

    // R4: read on an empty buffer is ignored
    step(0, 1, 0, 0, "R4");
    // fill to the top, then a refused write (R3)
    for (int i = 0; i < D; i++) step(1, 0, 0, 0, "R10");
    step(1, 0, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");
    // drain: order preserved and refused words never appear (R1, R3)
    for (int i = 0; i < D; i++) step(0, 1, 0, 0, "R1");
    step(0, 1, 0, 0, "R4");

    // simultaneous read and write, long enough to wrap the positions (R5)
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R1");
    for (int i = 0; i < 3 * D; i++) step(1, 1, 0, 0, "R5");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R1");

    // R2: saved position is zero after reset
    do_reset();
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R2");
    step(0, 1, 0, 0, "R2");
    step(0, 0, 0, 1, "R2");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R2");

    // save-point sweep with repeated rewinds (R6, R7, R8, R11)
    for (int k = 0; k < 10; k++) begin
      do_reset();
      for (int i = 0; i < 6; i++) step(1, 1, 0, 0, "R5");
      for (int i = 0; i < 10; i++) step(1, 0, 0, 0, "R1");
      for (int i = 0; i < k; i++) step(0, 1, 0, 0, "R1");
      step(0, 1, 1, 0, "R6");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R1");
      if (k % 2 == 1) step(1, 1, 0, 1, "R11");
      else            step(0, 1, 0, 1, "R7");
      while (mcnt > 0) step(0, 1, 0, 0, "R6");
      step(0, 0, 0, 1, "R8");
      for (int i = 0; i < 2; i++) step(0, 1, 0, 0, "R8");
      // save and rewind together: rewind wins, saved position kept (R9)
      step(0, 1, 1, 1, "R9");
      step(0, 1, 0, 0, "R9");
      step(0, 1, 0, 0, "R9");
      step(0, 0, 0, 1, "R9");
      step(0, 1, 0, 0, "R9");
    end

    // rewind with a full buffer gives the depth as count (R7)
    do_reset();
    for (int i = 0; i < D; i++) step(1, 0, 0, 0, "R10");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R1");
    step(0, 0, 0, 1, "R7");
    step(1, 0, 0, 0, "R3");
    for (int i = 0; i < D; i++) step(0, 1, 0, 0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule